// File: doc/BRIEF.md
# Low-Power Watchdog Timer

The block is a watchdog counter that lives in a slow watchdog clock domain. Once software enables it, the counter advances on each watchdog clock edge. If software fails to clear it before a programmable deadline, the block requests a system reset. Software reaches the block from the CPU clock domain in two ways: a control word write and a clear command. Each request is held in a CPU-side holding register and handed across to the watchdog domain by a toggle handshake. While a request is still in flight, a busy flag stays high, and any new request is dropped.

The control word holds these fields:
- an enable bit;
- a 4-bit deadline selector;
- a 2-bit oscillator source selector;
- three freeze-policy bits, covering debug halt, deep sleep and stop sleep;
- a bit that vetoes the deepest shutdown mode;
- a bit that keeps the watchdog oscillator from being switched off;
- a sticky lock.

The counter freezes and resumes on its own under each freeze condition that is set. When it times out, the block emits a one-cycle reset request and disarms itself.

Top module: `wdt_top`

## Requirements
- R1: After reset, `busy`, `rstReq`, `shutdownBlock` and `oscKeep` are 0, and `srcSel` is 0.
- R2: While enabled and counting, `rstReq` goes high for exactly one watchdog cycle on the counting edge numbered 2^(3+P)+1 after the counter last left zero. P is the period field, `wrData[12:9]`.
- R3: A request is taken when `wrCtrl` or `wrClear` is high on a `cpuClk` edge while `busy` is low. With both clocks tied together, the request takes effect on the third edge after that. `busy` is high for the five cycles that follow acceptance. A request made while `busy` is high is ignored.
- R4: An accepted clear command (`wrClear`) returns the counter to zero, and a full deadline starts again. A clear that lands on the same edge as a timeout suppresses that timeout.
- R5: The timeout edge returns the counter to zero and sets the enable bit to 0. No further request follows until software enables the block again.
- R6: While the enable bit (`wrData[0]`) is 0, the counter sits at zero and `rstReq` stays low.
- R7: With `wrData[1]` (run-in-halt) at 0, the counter holds its value while `dbgHalt` is high and resumes from that value afterwards. With the bit at 1, `dbgHalt` has no effect.
- R8: `sleepMode` is coded 0 = active, 1 = light sleep, 2 = deep sleep, 3 = stop. The counter always runs in active and light sleep. In deep sleep it runs only if `wrData[2]` is 1. In stop it runs only if `wrData[3]` is 1. Otherwise it freezes and resumes from the held value.
- R9: `shutdownBlock` follows control bit `wrData[4]`, and `oscKeep` follows control bit `wrData[5]`.
- R10: Once a control word with `wrData[6]` (lock) set has taken effect, later control writes change nothing, while clear commands still work. Only reset releases the lock.
- R11: `srcSel` follows `wrData[8:7]`. The unused code 3 is stored as 0, which selects the always-on 1 kHz source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuClk | input | 1 | CPU-side clock |
| cpuRstN | input | 1 | CPU-side active-low reset |
| wdClk | input | 1 | Watchdog clock |
| wdRstN | input | 1 | Watchdog-domain active-low reset |
| wrCtrl | input | 1 | Control word write request |
| wrClear | input | 1 | Counter clear request |
| wrData | input | 13 | Control word: [0] enable, [1] run-in-halt, [2] run-in-deep, [3] run-in-stop, [4] shutdown veto, [5] oscillator keep, [6] lock, [8:7] source, [12:9] period |
| busy | output | 1 | A request is crossing domains |
| dbgHalt | input | 1 | Debugger has halted the core |
| sleepMode | input | 2 | Current sleep level |
| rstReq | output | 1 | One-cycle system reset request |
| shutdownBlock | output | 1 | Vetoes entry into the deepest shutdown mode |
| oscKeep | output | 1 | Keeps the watchdog oscillator from being disabled |
| srcSel | output | 2 | Selected watchdog clock source |

## Verification
The bench builds the block with its default base exponent of 3 and two synchronizer stages. It drives both clock inputs from a single clock, so the crossing latency and the busy window fall on exact, predictable cycles. With these defaults, the 9-, 17- and 33-cycle deadlines are short enough to test every freeze combination and the clear-versus-timeout race. A single run at period 13 (65537 cycles) exercises the upper bits of the counter and the threshold logic.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PERIOD_W = 4;
  localparam int SRC_W    = 2;
  localparam int SLEEP_W  = 2;

  localparam logic [SLEEP_W-1:0] SLP_ACTIVE = 2'd0;
  localparam logic [SLEEP_W-1:0] SLP_LIGHT  = 2'd1;
  localparam logic [SLEEP_W-1:0] SLP_DEEP   = 2'd2;
  localparam logic [SLEEP_W-1:0] SLP_STOP   = 2'd3;

  localparam logic [SRC_W-1:0] SRC_UNUSED = 2'd3;
  localparam logic [SRC_W-1:0] SRC_ALWAYS = 2'd0;

  typedef struct packed {
    logic [PERIOD_W-1:0] period;
    logic [SRC_W-1:0]    srcSel;
    logic                lock;
    logic                oscHold;
    logic                blockShutdown;
    logic                runInStop;
    logic                runInDeep;
    logic                runInHalt;
    logic                enable;
  } wdt_ctrl_t;

  localparam int CTRL_W = $bits(wdt_ctrl_t);

  typedef struct packed {
    logic clearCnt;
    logic zeroCnt;
    logic stepCnt;
  } wdt_strobe_t;
endpackage

// File: rtl/wdt_xing.sv
module wdt_xing
  import wdt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      cpuClk,
  input  logic      cpuRstN,
  input  logic      wdClk,
  input  logic      wdRstN,
  input  logic      wrCtrl,
  input  logic      wrClear,
  input  wdt_ctrl_t wrWord,
  output logic      busy,
  output logic      applyCtrl,
  output logic      applyClear,
  output wdt_ctrl_t heldWord
);
  logic reqTog;
  logic holdCtrl;
  logic holdClear;
  logic [SYNC_STAGES-1:0] reqSync;
  logic [SYNC_STAGES-1:0] ackSync;
  logic seenTog;
  logic arrive;

  assign busy = reqTog ^ ackSync[SYNC_STAGES-1];

  always_ff @(posedge cpuClk or negedge cpuRstN) begin
    if (!cpuRstN) begin
      reqTog    <= 1'b0;
      holdCtrl  <= 1'b0;
      holdClear <= 1'b0;
      heldWord  <= '0;
    end else if ((wrCtrl || wrClear) && !busy) begin
      reqTog    <= ~reqTog;
      holdCtrl  <= wrCtrl;
      holdClear <= wrClear;
      if (wrCtrl) heldWord <= wrWord;
    end
  end

  always_ff @(posedge cpuClk or negedge cpuRstN) begin
    if (!cpuRstN) ackSync <= '0;
    else begin
      ackSync[0] <= seenTog;
      for (int i = 1; i < SYNC_STAGES; i++) ackSync[i] <= ackSync[i-1];
    end
  end

  always_ff @(posedge wdClk or negedge wdRstN) begin
    if (!wdRstN) begin
      reqSync <= '0;
      seenTog <= 1'b0;
    end else begin
      reqSync[0] <= reqTog;
      for (int i = 1; i < SYNC_STAGES; i++) reqSync[i] <= reqSync[i-1];
      seenTog <= reqSync[SYNC_STAGES-1];
    end
  end

  assign arrive     = reqSync[SYNC_STAGES-1] ^ seenTog;
  assign applyCtrl  = arrive && holdCtrl;
  assign applyClear = arrive && holdClear;
endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
(
  input  logic               wdClk,
  input  logic               wdRstN,
  input  logic               applyCtrl,
  input  logic               applyClear,
  input  wdt_ctrl_t          heldWord,
  input  logic               timeout,
  input  logic               dbgHalt,
  input  logic [SLEEP_W-1:0] sleepMode,
  output wdt_ctrl_t          ctrlQ,
  output wdt_strobe_t        stb
);
  logic haltFreeze;
  logic sleepFreeze;
  wdt_ctrl_t nextWord;

  always_comb begin
    nextWord = heldWord;
    if (heldWord.srcSel == SRC_UNUSED) nextWord.srcSel = SRC_ALWAYS;
  end

  always_ff @(posedge wdClk or negedge wdRstN) begin
    if (!wdRstN) begin
      ctrlQ <= '0;
    end else begin
      if (applyCtrl && !ctrlQ.lock) ctrlQ <= nextWord;
      if (timeout) ctrlQ.enable <= 1'b0;
    end
  end

  assign haltFreeze = dbgHalt && !ctrlQ.runInHalt;

  always_comb begin
    unique case (sleepMode)
      SLP_DEEP: sleepFreeze = !ctrlQ.runInDeep;
      SLP_STOP: sleepFreeze = !ctrlQ.runInStop;
      default:  sleepFreeze = 1'b0;
    endcase
  end

  assign stb.clearCnt = applyClear;
  assign stb.zeroCnt  = !ctrlQ.enable;
  assign stb.stepCnt  = ctrlQ.enable && !haltFreeze && !sleepFreeze;
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 3
) (
  input  logic                wdClk,
  input  logic                wdRstN,
  input  wdt_strobe_t         stb,
  input  logic [PERIOD_W-1:0] period,
  output logic                timeout,
  output logic                rstReq,
  output logic [BASE_EXP+(1<<PERIOD_W)-1:0] count
);
  localparam int CNT_W = BASE_EXP + (1 << PERIOD_W);

  logic [CNT_W-1:0] threshold;
  logic [CNT_W-1:0] countNext;
  logic             hit;

  assign threshold = (CNT_W'(1) << (BASE_EXP + int'(period))) + CNT_W'(1);
  assign countNext = count + CNT_W'(1);
  assign hit       = stb.stepCnt && (countNext == threshold);
  assign timeout   = hit && !stb.clearCnt;

  always_ff @(posedge wdClk or negedge wdRstN) begin
    if (!wdRstN) begin
      count  <= '0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= timeout;
      if (stb.clearCnt || stb.zeroCnt || hit) count <= '0;
      else if (stb.stepCnt)                   count <= countNext;
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int BASE_EXP    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               cpuClk,
  input  logic               cpuRstN,
  input  logic               wdClk,
  input  logic               wdRstN,
  input  logic               wrCtrl,
  input  logic               wrClear,
  input  logic [CTRL_W-1:0]  wrData,
  output logic               busy,
  input  logic               dbgHalt,
  input  logic [SLEEP_W-1:0] sleepMode,
  output logic               rstReq,
  output logic               shutdownBlock,
  output logic               oscKeep,
  output logic [SRC_W-1:0]   srcSel
);
  localparam int CNT_W = BASE_EXP + (1 << PERIOD_W);

  wdt_ctrl_t        heldWord;
  wdt_ctrl_t        ctrlQ;
  wdt_strobe_t      stb;
  logic             applyCtrl;
  logic             applyClear;
  logic             timeout;
  logic [CNT_W-1:0] count;

  wdt_xing #(.SYNC_STAGES(SYNC_STAGES)) u_xing (
    .cpuClk(cpuClk), .cpuRstN(cpuRstN), .wdClk(wdClk), .wdRstN(wdRstN),
    .wrCtrl(wrCtrl), .wrClear(wrClear), .wrWord(wdt_ctrl_t'(wrData)),
    .busy(busy), .applyCtrl(applyCtrl), .applyClear(applyClear),
    .heldWord(heldWord)
  );

  wdt_control u_control (
    .wdClk(wdClk), .wdRstN(wdRstN), .applyCtrl(applyCtrl),
    .applyClear(applyClear), .heldWord(heldWord), .timeout(timeout),
    .dbgHalt(dbgHalt), .sleepMode(sleepMode), .ctrlQ(ctrlQ), .stb(stb)
  );

  wdt_datapath #(.BASE_EXP(BASE_EXP)) u_datapath (
    .wdClk(wdClk), .wdRstN(wdRstN), .stb(stb), .period(ctrlQ.period),
    .timeout(timeout), .rstReq(rstReq), .count(count)
  );

  assign shutdownBlock = ctrlQ.blockShutdown;
  assign oscKeep       = ctrlQ.oscHold;
  assign srcSel        = ctrlQ.srcSel;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 19
) (
  input logic             cpuClk,
  input logic             cpuRstN,
  input logic             wdClk,
  input logic             wdRstN,
  input logic             busy,
  input logic             rstReq,
  input logic             enable,
  input logic             lock,
  input logic             dbgHalt,
  input logic             runInHalt,
  input logic             clrStb,
  input logic [CNT_W-1:0] count
);
  a_r2_single_pulse: assert property (@(posedge wdClk) disable iff (!wdRstN)
    rstReq |=> !rstReq);

  a_r5_disarm_on_fire: assert property (@(posedge wdClk) disable iff (!wdRstN)
    rstReq |-> (!enable && count == '0));

  a_r6_quiet_when_off: assert property (@(posedge wdClk) disable iff (!wdRstN)
    !enable |=> !rstReq);

  a_r7_halt_freeze: assert property (@(posedge wdClk) disable iff (!wdRstN)
    (enable && dbgHalt && !runInHalt && !clrStb) |=> $stable(count));

  a_r10_lock_sticky: assert property (@(posedge wdClk) disable iff (!wdRstN)
    lock |=> lock);

  a_r3_busy_lasts: assert property (@(posedge cpuClk) disable iff (!cpuRstN)
    $rose(busy) |=> busy);
endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W)) u_wdtChk (
  .cpuClk(cpuClk), .cpuRstN(cpuRstN), .wdClk(wdClk), .wdRstN(wdRstN),
  .busy(busy), .rstReq(rstReq), .enable(ctrlQ.enable), .lock(ctrlQ.lock),
  .dbgHalt(dbgHalt), .runInHalt(ctrlQ.runInHalt), .clrStb(stb.clearCnt),
  .count(count)
);

// File: tb/wdt_top_bench.sv
`timescale 1ns/1ps
module wdt_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrCtrl = 1'b0, wrClear = 1'b0;
  logic [12:0] wrData = '0;
  logic dbgHalt = 1'b0;
  logic [1:0] sleepMode = 2'd0;
  logic busy, rstReq, shutdownBlock, oscKeep;
  logic [1:0] srcSel;

  int checks = 0, failures = 0, pulses = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wdt_top u_wdt_top (
    .cpuClk(clk), .cpuRstN(rstN), .wdClk(clk), .wdRstN(rstN),
    .wrCtrl(wrCtrl), .wrClear(wrClear), .wrData(wrData), .busy(busy),
    .dbgHalt(dbgHalt), .sleepMode(sleepMode), .rstReq(rstReq),
    .shutdownBlock(shutdownBlock), .oscKeep(oscKeep), .srcSel(srcSel)
  );

  // behavioural reference model
  int edgeN, lastW, mCnt, pendDue, mPer;
  bit mEn, mRih, mRid, mRis, mShut, mOsc, mLock, mFire, pend, pCtl, pClr;
  int mSrc;
  logic [12:0] pData;

  always @(posedge clk) begin
    if (!rstN) begin
      edgeN = 0; lastW = -100; mCnt = 0; pend = 0; mPer = 0; mSrc = 0;
      {mEn, mRih, mRid, mRis, mShut, mOsc, mLock, mFire} = '0;
    end else begin
      bit busyB, app, run, fire;
      int nE, lim;
      busyB = (edgeN < lastW + 5);
      nE = edgeN + 1;
      app = pend && (pendDue == nE);
      run = mEn && !(dbgHalt && !mRih) && !(sleepMode == 2 && !mRid)
                && !(sleepMode == 3 && !mRis);
      lim = (1 << (3 + mPer)) + 1;
      fire = 0;
      if (app && pClr) mCnt = 0;
      else if (!mEn) mCnt = 0;
      else if (run) begin
        if (mCnt + 1 == lim) begin fire = 1; mCnt = 0; end
        else mCnt++;
      end
      if (app && pCtl && !mLock) begin
        mEn = pData[0]; mRih = pData[1]; mRid = pData[2]; mRis = pData[3];
        mShut = pData[4]; mOsc = pData[5]; mLock = pData[6];
        mSrc = (pData[8:7] == 2'd3) ? 0 : int'(pData[8:7]);
        mPer = int'(pData[12:9]);
      end
      if (fire) mEn = 0;
      if (app) pend = 0;
      if ((wrCtrl || wrClear) && !busyB) begin
        pend = 1; pendDue = nE + 3; lastW = nE;
        pCtl = wrCtrl; pClr = wrClear; pData = wrData;
      end
      edgeN = nE; mFire = fire;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk({curReq, " rstReq"}, int'(rstReq), int'(mFire));
      chk({curReq, " busy"}, int'(busy), int'(edgeN < lastW + 5));
      chk("R9 shutdownBlock", int'(shutdownBlock), int'(mShut));
      chk("R9 oscKeep", int'(oscKeep), int'(mOsc));
      chk("R11 srcSel", int'(srcSel), mSrc);
      if (rstReq) pulses++;
    end
  end

  function automatic logic [12:0] mk(bit en, bit rih, bit rid, bit ris,
      bit shut, bit osc, bit lk, logic [1:0] src, logic [3:0] per);
    return {per, src, lk, osc, shut, ris, rid, rih, en};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(bit c, bit k, logic [12:0] d);
    wrCtrl = c; wrClear = k; wrData = d;
    @(negedge clk);
    wrCtrl = 1'b0; wrClear = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(4);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 rstReq", int'(rstReq), 0);
    chk("R1 shutdownBlock", int'(shutdownBlock), 0);
    chk("R1 oscKeep", int'(oscKeep), 0);
    chk("R1 srcSel", int'(srcSel), 0);

    // R6 disabled never fires
    curReq = "R6"; pulses = 0;
    issue(1, 0, mk(0,0,0,0,0,0,0,2'd0,4'd0)); tick(40);
    chk("R6 pulses", pulses, 0);

    // R2/R5 period 0 and 2, one pulse then disarmed
    curReq = "R2"; pulses = 0;
    issue(1, 0, mk(1,0,0,0,0,0,0,2'd0,4'd0)); tick(20);
    chk("R2 pulses p0", pulses, 1);
    curReq = "R5"; tick(40);
    chk("R5 no refire", pulses, 1);
    curReq = "R2"; pulses = 0;
    issue(1, 0, mk(1,0,0,0,0,0,0,2'd0,4'd2)); tick(50);
    chk("R2 pulses p2", pulses, 1);

    // R4 clears keep it alive
    curReq = "R4"; pulses = 0;
    issue(1, 0, mk(1,0,0,0,0,0,0,2'd0,4'd1)); tick(6);
    for (int i = 0; i < 6; i++) begin
      tick(4); issue(0, 1, '0); tick(5);
    end
    chk("R4 fed no pulse", pulses, 0);
    tick(30);
    chk("R4 starved pulse", pulses, 1);

    // R3 request while busy is dropped
    curReq = "R3";
    issue(1, 0, mk(0,0,0,0,1,0,0,2'd0,4'd0));
    chk("R3 busy after write", int'(busy), 1);
    issue(1, 0, mk(0,0,0,0,0,1,0,2'd0,4'd0));
    tick(8);
    chk("R3 busy drops", int'(busy), 0);
    chk("R3 first kept", int'(shutdownBlock), 1);
    chk("R3 second dropped", int'(oscKeep), 0);

    // R7 debug halt
    curReq = "R7"; pulses = 0; dbgHalt = 1'b1;
    issue(1, 0, mk(1,0,0,0,0,0,0,2'd0,4'd2)); tick(60);
    chk("R7 frozen", pulses, 0);
    dbgHalt = 1'b0; tick(50);
    chk("R7 resumes", pulses, 1);
    pulses = 0; dbgHalt = 1'b1;
    issue(1, 0, mk(1,1,0,0,0,0,0,2'd0,4'd2)); tick(50);
    chk("R7 runs in halt", pulses, 1);
    dbgHalt = 1'b0;

    // R8 sleep modes
    curReq = "R8"; pulses = 0; sleepMode = 2'd2;
    issue(1, 0, mk(1,0,0,0,0,0,0,2'd0,4'd1)); tick(40);
    chk("R8 deep frozen", pulses, 0);
    sleepMode = 2'd1; tick(30);
    chk("R8 light runs", pulses, 1);
    pulses = 0; sleepMode = 2'd3;
    issue(1, 0, mk(1,0,0,1,0,0,0,2'd0,4'd1)); tick(30);
    chk("R8 stop runs", pulses, 1);
    pulses = 0;
    issue(1, 0, mk(1,0,1,0,0,0,0,2'd0,4'd1)); tick(40);
    chk("R8 stop frozen", pulses, 0);
    sleepMode = 2'd2; tick(30);
    chk("R8 deep runs", pulses, 1);
    sleepMode = 2'd0;

    // R9 / R11 static outputs
    curReq = "R9";
    issue(1, 0, mk(0,0,0,0,0,1,0,2'd3,4'd0)); tick(6);
    chk("R9 osc set", int'(oscKeep), 1);
    chk("R11 code3 to 0", int'(srcSel), 0);
    issue(1, 0, mk(0,0,0,0,1,0,0,2'd2,4'd0)); tick(6);
    chk("R9 shut set", int'(shutdownBlock), 1);
    chk("R11 src2", int'(srcSel), 2);

    // R2 long period 13
    curReq = "R2"; pulses = 0;
    issue(1, 0, mk(1,0,0,0,0,0,0,2'd1,4'd13)); tick(65530);
    chk("R2 p13 early", pulses, 0);
    tick(20);
    chk("R2 p13 fires", pulses, 1);

    // R10 lock
    curReq = "R10"; pulses = 0;
    issue(1, 0, mk(0,0,0,0,1,0,1,2'd1,4'd0)); tick(6);
    issue(1, 0, mk(1,0,0,0,0,1,0,2'd2,4'd0)); tick(30);
    chk("R10 shut held", int'(shutdownBlock), 1);
    chk("R10 osc held", int'(oscKeep), 0);
    chk("R10 no enable", pulses, 0);
    issue(0, 1, '0);
    chk("R10 clear accepted", int'(busy), 1);
    tick(8);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule